// File: doc/BRIEF.md
# Integer ALU with Carry and Overflow Flags

This block is the single-cycle 32-bit integer execution stage of a small RISC core. The core presents two operands, a 4-bit operation code and the 4-bit sub-operation field taken from instruction bits 9:6. The block returns a result in the same cycle. It covers addition with and without an incoming carry, subtraction, the three bitwise logic operations, four shift and rotate kinds, sign and zero extension, a flag-driven select, and two bit-scan operations.

The core keeps the carry flag, the overflow flag and the compare flag in its status register and feeds them in. The block returns the next carry and overflow values for the core to write back. Only the three arithmetic operations change those two flags; every other operation hands them back unchanged. An arithmetic overflow that occurs while the overflow-exception enable is set raises a range-exception request in the same cycle.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) returns A+B modulo 2^32. The next carry is the unsigned carry out of bit 31. The next overflow is the two's-complement signed overflow.
- R2: Code 1 (add with carry) returns A+B+carryIn. Carry and overflow come from that three-input sum, using the carry flag held before the operation.
- R3: Code 2 (subtract) returns A-B. The next carry is the borrow, which is 1 when A is below B as unsigned values. The next overflow is the signed overflow of A-B.
- R4: Code 3 returns A AND B, code 4 returns A OR B, and code 5 returns A XOR B.
- R5: Code 8 shifts A by B[4:0]. Sub-operation bits 1:0 choose the kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The upper bits of B have no effect.
- R6: Code 12 extends A according to the whole sub-operation field: 0 sign-extends bits 15:0, 1 sign-extends bits 7:0, 2 zero-extends bits 15:0, 3 zero-extends bits 7:0. Any field value above 3 returns A unchanged.
- R7: Code 13 (word extend) returns A unchanged for every sub-operation value.
- R8: Code 14 returns A when flagIn is 1 and B when flagIn is 0.
- R9: Code 15 scans A. With sub-operation bit 2 clear it returns the 1-based index of the lowest set bit. With that bit set it returns the 1-based index of the highest set bit. Both return 0 when A is zero.
- R10: For every code other than 0, 1 and 2, carryOut equals carryIn and overflowOut equals overflowIn.
- R11: rangeExc is 1 exactly when the code is 0, 1 or 2, the new overflow is 1, and ovExcEn is 1. A stale overflowIn never raises it.
- R12: The unassigned codes 6, 7, 9, 10 and 11 return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, or the shift amount |
| aluOp | input | 4 | Operation code |
| subOp | input | 4 | Sub-operation field (instruction bits 9:6) |
| carryIn | input | 1 | Current carry flag |
| overflowIn | input | 1 | Current overflow flag |
| flagIn | input | 1 | Current compare flag, used by the select |
| ovExcEn | input | 1 | Overflow-exception enable |
| result | output | 32 | Operation result |
| carryOut | output | 1 | Next carry flag |
| overflowOut | output | 1 | Next overflow flag |
| rangeExc | output | 1 | Range-exception request |

## Verification
The flag update and the range-exception request are produced in the same cycle, and the request must follow the freshly computed overflow, not the one held in the status register. Directed vectors create signed overflow on add, add-with-carry and subtract, once with the enable set and once with it cleared. Further vectors run logic and shift operations with overflowIn and ovExcEn both set. The bench reference model decides each expected request from its own signed arithmetic. Random operations also toggle both flags and the enable independently.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADDC  = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_AND   = 4'd3;
  localparam logic [3:0] OP_OR    = 4'd4;
  localparam logic [3:0] OP_XOR   = 4'd5;
  localparam logic [3:0] OP_SHIFT = 4'd8;
  localparam logic [3:0] OP_EXTBH = 4'd12;
  localparam logic [3:0] OP_EXTW  = 4'd13;
  localparam logic [3:0] OP_CMOV  = 4'd14;
  localparam logic [3:0] OP_SCAN  = 4'd15;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ARITH, SEL_LOGIC, SEL_SHIFT,
    SEL_EXT, SEL_PASSA, SEL_CMOV, SEL_SCAN
  } resSel_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NONE} logicKind_e;

  typedef struct packed {
    resSel_e    resSel;
    logic       subMode;
    logic       carryChain;
    logicKind_e logicKind;
    logic [1:0] shiftKind;
    logic [1:0] extKind;
    logic       scanLast;
    logic       flagWrite;
  } aluStrobe_t;

endpackage

// File: rtl/alu_bitscan.sv
module alu_bitscan #(
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] firstIdx,
  output logic [IDX_W-1:0] lastIdx
);

  logic [IDX_W-1:0] lowPick [WIDTH+1];
  logic [IDX_W-1:0] highPick [WIDTH+1];

  assign lowPick[WIDTH] = '0;
  assign highPick[0]    = '0;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_scan
      // lowest set bit wins by searching from the top down
      assign lowPick[gi] = vecIn[gi] ? IDX_W'(gi + 1) : lowPick[gi+1];
      // highest set bit wins by searching from the bottom up
      assign highPick[gi+1] = vecIn[gi] ? IDX_W'(gi + 1) : highPick[gi];
    end
  endgenerate

  assign firstIdx = lowPick[0];
  assign lastIdx  = highPick[WIDTH];

  always_comb begin
    a_r9_scan_zero: assert ((firstIdx == '0) == (vecIn == '0));
    a_r9_scan_order: assert (vecIn == '0 || firstIdx <= lastIdx);
  end

endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] aluOp,
  input  logic [3:0] subOp,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '{resSel: SEL_ZERO, subMode: 1'b0, carryChain: 1'b0,
               logicKind: LG_NONE, shiftKind: 2'd0, extKind: 2'd0,
               scanLast: 1'b0, flagWrite: 1'b0};
    unique case (aluOp)
      OP_ADD: begin
        strobe.resSel    = SEL_ARITH;
        strobe.flagWrite = 1'b1;
      end
      OP_ADDC: begin
        strobe.resSel     = SEL_ARITH;
        strobe.carryChain = 1'b1;
        strobe.flagWrite  = 1'b1;
      end
      OP_SUB: begin
        strobe.resSel    = SEL_ARITH;
        strobe.subMode   = 1'b1;
        strobe.flagWrite = 1'b1;
      end
      OP_AND: begin
        strobe.resSel    = SEL_LOGIC;
        strobe.logicKind = LG_AND;
      end
      OP_OR: begin
        strobe.resSel    = SEL_LOGIC;
        strobe.logicKind = LG_OR;
      end
      OP_XOR: begin
        strobe.resSel    = SEL_LOGIC;
        strobe.logicKind = LG_XOR;
      end
      OP_SHIFT: begin
        strobe.resSel    = SEL_SHIFT;
        strobe.shiftKind = subOp[1:0];
      end
      OP_EXTBH: begin
        if (subOp[3:2] == 2'b00) begin
          strobe.resSel  = SEL_EXT;
          strobe.extKind = subOp[1:0];
        end else begin
          strobe.resSel  = SEL_PASSA;
        end
      end
      OP_EXTW: strobe.resSel = SEL_PASSA;
      OP_CMOV: strobe.resSel = SEL_CMOV;
      OP_SCAN: begin
        strobe.resSel   = SEL_SCAN;
        strobe.scanLast = subOp[2];
      end
      default: strobe.resSel = SEL_ZERO;
    endcase
  end

  always_comb begin
    a_r3_sub_alone: assert (!strobe.subMode || (!strobe.carryChain && aluOp == OP_SUB));
    a_r10_flag_codes: assert (!strobe.flagWrite || aluOp <= OP_SUB);
    a_r12_zero_codes: assert (strobe.resSel != SEL_ZERO ||
                              aluOp inside {4'd6, 4'd7, 4'd9, 4'd10, 4'd11});
  end

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int SH_W = $clog2(WIDTH),
  localparam int IDX_W = $clog2(WIDTH + 1)
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             overflowIn,
  input  logic             flagIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflowOut
);

  // shared adder: subtraction adds the inverted operand plus one
  logic [WIDTH-1:0] addB;
  logic             addCin;
  logic [WIDTH:0]   sumWide;
  logic             arithOv;

  assign addB    = strobe.subMode ? ~opB : opB;
  assign addCin  = strobe.subMode | (strobe.carryChain & carryIn);
  assign sumWide = {1'b0, opA} + {1'b0, addB} + {{WIDTH{1'b0}}, addCin};
  assign arithOv = (opA[WIDTH-1] == addB[WIDTH-1]) &&
                   (sumWide[WIDTH-1] != opA[WIDTH-1]);

  logic [WIDTH-1:0] logicRes;
  always_comb begin
    unique case (strobe.logicKind)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = '0;
    endcase
  end

  logic [SH_W-1:0]    shAmt;
  logic [2*WIDTH-1:0] rotWide;
  logic [WIDTH-1:0]   shiftRes;
  assign shAmt   = opB[SH_W-1:0];
  assign rotWide = {opA, opA} >> shAmt;
  always_comb begin
    unique case (strobe.shiftKind)
      2'd0: shiftRes = opA << shAmt;
      2'd1: shiftRes = opA >> shAmt;
      2'd2: shiftRes = WIDTH'($signed(opA) >>> shAmt);
      default: shiftRes = rotWide[WIDTH-1:0];
    endcase
  end

  logic [WIDTH-1:0] extRes;
  always_comb begin
    unique case (strobe.extKind)
      2'd0: extRes = {{(WIDTH-HALF_W){opA[HALF_W-1]}}, opA[HALF_W-1:0]};
      2'd1: extRes = {{(WIDTH-BYTE_W){opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};
      2'd2: extRes = {{(WIDTH-HALF_W){1'b0}}, opA[HALF_W-1:0]};
      default: extRes = {{(WIDTH-BYTE_W){1'b0}}, opA[BYTE_W-1:0]};
    endcase
  end

  logic [IDX_W-1:0] firstIdx;
  logic [IDX_W-1:0] lastIdx;
  alu_bitscan #(.WIDTH(WIDTH)) u_scan (
    .vecIn   (opA),
    .firstIdx(firstIdx),
    .lastIdx (lastIdx)
  );

  always_comb begin
    unique case (strobe.resSel)
      SEL_ARITH: result = sumWide[WIDTH-1:0];
      SEL_LOGIC: result = logicRes;
      SEL_SHIFT: result = shiftRes;
      SEL_EXT:   result = extRes;
      SEL_PASSA: result = opA;
      SEL_CMOV:  result = flagIn ? opA : opB;
      SEL_SCAN:  result = WIDTH'(strobe.scanLast ? lastIdx : firstIdx);
      default:   result = '0;
    endcase
  end

  // borrow is the inverse of the adder carry when subtracting
  assign carryOut    = strobe.flagWrite ? (sumWide[WIDTH] ^ strobe.subMode) : carryIn;
  assign overflowOut = strobe.flagWrite ? arithOv : overflowIn;

  always_comb begin
    a_r10_flags_hold: assert (strobe.flagWrite ||
                              (carryOut == carryIn && overflowOut == overflowIn));
    a_r8_select: assert (strobe.resSel != SEL_CMOV || result == (flagIn ? opA : opB));
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [3:0]  aluOp,
  input  logic [3:0]  subOp,
  input  logic        carryIn,
  input  logic        overflowIn,
  input  logic        flagIn,
  input  logic        ovExcEn,
  output logic [31:0] result,
  output logic        carryOut,
  output logic        overflowOut,
  output logic        rangeExc
);

  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .aluOp (aluOp),
    .subOp (subOp),
    .strobe(strobe)
  );

  alu_dpath #(.WIDTH(32)) u_dpath (
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .overflowIn (overflowIn),
    .flagIn     (flagIn),
    .result     (result),
    .carryOut   (carryOut),
    .overflowOut(overflowOut)
  );

  assign rangeExc = strobe.flagWrite & overflowOut & ovExcEn;

  always_comb begin
    a_r11_exc_needs_ov: assert (!rangeExc || (overflowOut && ovExcEn));
    a_r11_exc_arith_only: assert (!rangeExc || aluOp <= OP_SUB);
  end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] opA, opB, result;
  logic [3:0]  aluOp, subOp;
  logic carryIn, overflowIn, flagIn, ovExcEn;
  logic carryOut, overflowOut, rangeExc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int_alu uut (
    .opA(opA), .opB(opB), .aluOp(aluOp), .subOp(subOp),
    .carryIn(carryIn), .overflowIn(overflowIn), .flagIn(flagIn),
    .ovExcEn(ovExcEn), .result(result), .carryOut(carryOut),
    .overflowOut(overflowOut), .rangeExc(rangeExc)
  );

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'd0:  return "R1";
      4'd1:  return "R2";
      4'd2:  return "R3";
      4'd3, 4'd4, 4'd5: return "R4";
      4'd8:  return "R5";
      4'd12: return "R6";
      4'd13: return "R7";
      4'd14: return "R8";
      4'd15: return "R9";
      default: return "R12";
    endcase
  endfunction

  // reference model: returns {result, carry, overflow, exception}
  function automatic logic [34:0] refModel(
      input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
      input logic [3:0] sub, input logic cin, input logic oin,
      input logic fin, input logic en);
    logic [31:0] r;
    logic c, o, arith;
    logic [32:0] wide;
    logic [4:0] s;
    logic [63:0] rot;
    r = '0; c = cin; o = oin; arith = 1'b0;
    s = b[4:0];
    case (op)
      4'd0, 4'd1: begin
        wide = {1'b0, a} + {1'b0, b} + ((op == 4'd1 && cin) ? 33'd1 : 33'd0);
        r = wide[31:0]; c = wide[32];
        o = (a[31] == b[31]) && (r[31] != a[31]);
        arith = 1'b1;
      end
      4'd2: begin
        r = a - b; c = (a < b);
        o = (a[31] != b[31]) && (r[31] != a[31]);
        arith = 1'b1;
      end
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd8: begin
        rot = {a, a} >> s;
        case (sub[1:0])
          2'd0: r = a << s;
          2'd1: r = a >> s;
          2'd2: r = $unsigned($signed(a) >>> s);
          default: r = rot[31:0];
        endcase
      end
      4'd12: begin
        case (sub)
          4'd0: r = {{16{a[15]}}, a[15:0]};
          4'd1: r = {{24{a[7]}}, a[7:0]};
          4'd2: r = {16'd0, a[15:0]};
          4'd3: r = {24'd0, a[7:0]};
          default: r = a;
        endcase
      end
      4'd13: r = a;
      4'd14: r = fin ? a : b;
      4'd15: begin
        r = 0;
        if (sub[2]) begin
          for (int i = 0; i < 32; i++) if (a[i]) r = i + 1;
        end else begin
          for (int i = 31; i >= 0; i--) if (a[i]) r = i + 1;
        end
      end
      default: r = '0;
    endcase
    return {r, c, o, arith & o & en};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (op=%0d sub=%0d a=%h b=%h)",
               tag, what, act, exp, aluOp, subOp, opA, opB);
    end
  endtask

  task automatic applyAndCheck(input logic [31:0] a, input logic [31:0] b,
      input logic [3:0] op, input logic [3:0] sub, input logic cin,
      input logic oin, input logic fin, input logic en);
    logic [34:0] exp;
    @(posedge clk);
    opA = a; opB = b; aluOp = op; subOp = sub;
    carryIn = cin; overflowIn = oin; flagIn = fin; ovExcEn = en;
    exp = refModel(a, b, op, sub, cin, oin, fin, en);
    @(negedge clk);
    check(tagFor(op), "result", result, exp[34:3]);
    check((op <= 4'd2) ? tagFor(op) : "R10", "carry", {31'd0, carryOut}, {31'd0, exp[2]});
    check((op <= 4'd2) ? tagFor(op) : "R10", "overflow", {31'd0, overflowOut}, {31'd0, exp[1]});
    check("R11", "rangeExc", {31'd0, rangeExc}, {31'd0, exp[0]});
  endtask

  initial begin
    opA = '0; opB = '0; aluOp = '0; subOp = '0;
    carryIn = 0; overflowIn = 0; flagIn = 0; ovExcEn = 0;
    // idle state: add of zeros gives zero and no flags
    @(negedge clk);
    check("R1", "idle result", result, 32'd0);
    check("R11", "idle rangeExc", {31'd0, rangeExc}, 32'd0);

    // R1 overflow and carry corners, with and without enable
    applyAndCheck(32'h7fffffff, 32'h1, 4'd0, 4'd0, 0, 0, 0, 1);
    applyAndCheck(32'h7fffffff, 32'h1, 4'd0, 4'd0, 0, 0, 0, 0);
    applyAndCheck(32'hffffffff, 32'h1, 4'd0, 4'd0, 0, 1, 0, 1);
    // R2 incoming carry used
    applyAndCheck(32'h7ffffffe, 32'h1, 4'd1, 4'd0, 1, 0, 0, 1);
    applyAndCheck(32'hffffffff, 32'h0, 4'd1, 4'd0, 1, 0, 0, 0);
    // R3 borrow and signed overflow
    applyAndCheck(32'h80000000, 32'h1, 4'd2, 4'd0, 0, 0, 0, 1);
    applyAndCheck(32'h1, 32'h2, 4'd2, 4'd0, 0, 0, 0, 1);
    applyAndCheck(32'h5, 32'h5, 4'd2, 4'd0, 1, 1, 0, 1);
    // R10/R11 stale overflow on a logic op never raises the request
    applyAndCheck(32'hf0f0f0f0, 32'h0ff00ff0, 4'd3, 4'd0, 1, 1, 0, 1);
    applyAndCheck(32'h80000001, 32'h0, 4'd4, 4'd0, 0, 1, 1, 1);
    // R5 upper bits of B ignored, rotate and arithmetic right
    applyAndCheck(32'h80000001, 32'h25, 4'd8, 4'd3, 0, 1, 0, 1);
    applyAndCheck(32'h80000000, 32'hffffffe4, 4'd8, 4'd2, 1, 0, 0, 0);
    applyAndCheck(32'h12345678, 32'h0, 4'd8, 4'd3, 0, 0, 0, 0);
    // R6 variants and out-of-range field
    for (int v = 0; v < 6; v++)
      applyAndCheck(32'h00008080, 32'h0, 4'd12, 4'(v), 0, 0, 0, 0);
    // R7
    applyAndCheck(32'hdeadbeef, 32'h1, 4'd13, 4'd1, 1, 1, 0, 1);
    // R8
    applyAndCheck(32'haaaa5555, 32'h5555aaaa, 4'd14, 4'd0, 0, 0, 1, 0);
    applyAndCheck(32'haaaa5555, 32'h5555aaaa, 4'd14, 4'd0, 0, 0, 0, 0);
    // R9 scans including zero and single-bit edges
    applyAndCheck(32'h0, 32'h0, 4'd15, 4'd0, 0, 0, 0, 0);
    applyAndCheck(32'h0, 32'h0, 4'd15, 4'd4, 0, 0, 0, 0);
    applyAndCheck(32'h80000000, 32'h0, 4'd15, 4'd4, 0, 0, 0, 0);
    applyAndCheck(32'h80000000, 32'h0, 4'd15, 4'd0, 0, 0, 0, 0);
    applyAndCheck(32'h00010100, 32'h0, 4'd15, 4'd0, 0, 0, 0, 0);
    applyAndCheck(32'h00000001, 32'h0, 4'd15, 4'd4, 0, 0, 0, 0);
    // R12 unassigned codes
    applyAndCheck(32'hffffffff, 32'hffffffff, 4'd6, 4'd0, 1, 1, 1, 1);
    applyAndCheck(32'hffffffff, 32'hffffffff, 4'd10, 4'd0, 0, 1, 1, 1);

    // constrained random
    void'($urandom(32'd4242));
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] ra, rb;
      logic [3:0] rop;
      logic [3:0] flags;
      ra = $urandom(); rb = $urandom();
      case ($urandom_range(0, 5))
        0: ra = 32'h7fffffff;
        1: rb = 32'h80000000;
        2: ra = 32'h0;
        default: ;
      endcase
      rop = 4'($urandom_range(0, 15));
      flags = 4'($urandom());
      applyAndCheck(ra, rb, rop, 4'($urandom()), flags[0], flags[1], flags[2], flags[3]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule